// File: doc/BRIEF.md
# Two-Channel Conversion Sequencer

This block paces one conversion request that samples two channels in turn. A start request taken while idle raises a busy flag. The block then spends a fixed, parameterised number of clock cycles on channel 0, followed by the same number on channel 1. The analog conversion is modelled only as this cycle delay.

An active-low end-of-conversion strobe marks the end of each channel. When the second channel finishes, a one-cycle latch strobe tells the output shift register to capture both results. Busy drops in that same cycle, so a downstream reader can treat the falling edge of busy as "data ready".

A synchronous reset aborts any conversion in progress. A power-down input stops new conversions from starting but lets one already running reach its end.

Top module: `dual_conv_seq`

## Requirements
- R1: After reset the outputs are idle: busy=0, eoc_n=1, latch=0, chan=0.
- R2: A start sampled high while busy=0 and pwr_down=0 makes busy=1 from the next cycle. Busy then stays high for exactly 2*CONV_CYCLES cycles.
- R3: chan=0 during the first CONV_CYCLES busy cycles and chan=1 during the last CONV_CYCLES busy cycles. chan=0 whenever busy=0.
- R4: eoc_n is low for exactly one cycle at the end of each channel. The first low cycle is the cycle in which chan first reads 1. The second low cycle is the cycle in which busy falls. At all other times eoc_n is 1.
- R5: latch is high for exactly one cycle per completed conversion, in the cycle in which busy falls, and is never high at any other time.
- R6: A start sampled while busy=1 is ignored. The busy, chan, eoc_n and latch sequence of the running conversion is unchanged.
- R7: While pwr_down=1, a start does not raise busy. Raising pwr_down during a conversion does not shorten it or alter any of its outputs.
- R8: rst sampled high at any point of a conversion aborts it. From the next cycle the outputs are at their idle values, and no latch or eoc_n pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; aborts a running conversion |
| start | input | 1 | Conversion request, sampled on the rising clock edge |
| pwr_down | input | 1 | Blocks new conversions while high |
| busy | output | 1 | High from start acceptance until both results are latched |
| eoc_n | output | 1 | Active-low end-of-conversion strobe, one pulse per channel |
| latch | output | 1 | One-cycle capture strobe for the result shift register |
| chan | output | 1 | Index of the channel being converted (0 first, then 1) |

## Verification
A corrupted cycle counter shows up as a busy span of the wrong length, and it also moves both eoc_n pulses. That error is visible within one conversion, at most 2*CONV_CYCLES+1 cycles after start. A wrong channel bit either drops busy after a single channel, with a latch pulse too early, or keeps busy high past its expected falling cycle. The bench compares every output on every cycle of each conversion, so either fault shows within a single conversion. A missed abort or a start accepted while busy or powered down changes busy on the very next cycle.

// File: rtl/dual_conv_seq.sv
module dual_conv_seq #(
  parameter int CONV_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic pwr_down,
  output logic busy,
  output logic eoc_n,
  output logic latch,
  output logic chan
);
  localparam int CW = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CONV_CYCLES - 1);

  logic [CW-1:0] cnt;
  logic          ch_done;

  assign ch_done = busy && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      chan  <= 1'b0;
      cnt   <= '0;
      eoc_n <= 1'b1;
      latch <= 1'b0;
    end else begin
      eoc_n <= !ch_done;
      latch <= ch_done && chan;
      if (!busy) begin
        cnt  <= '0;
        chan <= 1'b0;
        if (start && !pwr_down) busy <= 1'b1;
      end else if (ch_done) begin
        cnt <= '0;
        if (chan) begin
          busy <= 1'b0;
          chan <= 1'b0;
        end else begin
          chan <= 1'b1;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

module dual_conv_seq_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic pwr_down,
  input logic busy,
  input logic eoc_n,
  input logic latch,
  input logic chan
);
  a_r8_reset_idle: assert property (@(posedge clk)
    rst |=> (!busy && eoc_n && !latch && !chan));

  a_r2_start_accept: assert property (@(posedge clk) disable iff (rst)
    (!busy && start && !pwr_down) |=> busy);

  a_r7_pd_blocks: assert property (@(posedge clk) disable iff (rst)
    (!busy && pwr_down) |=> !busy);

  a_r3_chan_idle: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !chan);

  a_r4_eoc_single: assert property (@(posedge clk) disable iff (rst)
    !eoc_n |=> eoc_n);

  a_r5_latch_on_fall: assert property (@(posedge clk) disable iff (rst)
    latch |-> $fell(busy));

  a_r5_fall_has_latch: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !$past(rst)) |-> (latch && !eoc_n));
endmodule

bind dual_conv_seq dual_conv_seq_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .pwr_down(pwr_down),
  .busy(busy), .eoc_n(eoc_n), .latch(latch), .chan(chan)
);

// File: tb/sim_dual_conv_seq.sv
module sim_dual_conv_seq;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic pwr_down = 1'b0;
  logic busy, eoc_n, latch, chan;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dual_conv_seq #(.CONV_CYCLES(N)) u0 (
    .clk(clk), .rst(rst), .start(start), .pwr_down(pwr_down),
    .busy(busy), .eoc_n(eoc_n), .latch(latch), .chan(chan)
  );

  task automatic check(string req, string what, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  // kind: 0 plain, 1 extra start at k=p (R6), 2 pd raised from k=p (R7), 3 reset at k=p (R8)
  task automatic run(int kind, int p);
    string tb, tc, te, tl;
    tb = "R2"; tc = "R3"; te = "R4"; tl = "R5";
    if (kind == 1) begin tb = "R6"; tc = "R6"; te = "R6"; tl = "R6"; end
    if (kind == 2) begin tb = "R7"; tc = "R7"; te = "R7"; tl = "R7"; end
    if (kind == 3) begin tb = "R8"; tc = "R8"; te = "R8"; tl = "R8"; end
    @(negedge clk);
    start = 1'b1;
    for (int k = 1; k <= 2*N + 2; k++) begin
      logic eb, ec, ee, el;
      @(negedge clk);
      eb = (k <= 2*N);
      ec = (k > N) && (k <= 2*N);
      ee = !((k == N + 1) || (k == 2*N + 1));
      el = (k == 2*N + 1);
      if (kind == 3 && k > p) begin eb = 0; ec = 0; ee = 1; el = 0; end
      check(tb, "busy", busy, eb);
      check(tc, "chan", chan, ec);
      check(te, "eoc_n", eoc_n, ee);
      check(tl, "latch", latch, el);
      start    = (kind == 1) && (k == p);
      pwr_down = (kind == 2) && (k >= p);
      rst      = (kind == 3) && (k == p);
    end
    start = 1'b0;
    rst = 1'b0;
    if (kind == 2) begin
      start = 1'b1;
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        check("R7", "busy under pwr_down", busy, 1'b0);
      end
      start = 1'b0;
      pwr_down = 1'b0;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "busy", busy, 1'b0);
    check("R1", "eoc_n", eoc_n, 1'b1);
    check("R1", "latch", latch, 1'b0);
    check("R1", "chan", chan, 1'b0);
    rst = 1'b0;
    run(0, 0);
    run(0, 0);
    for (int p = 1; p <= 2*N; p++) run(1, p);
    for (int p = 1; p <= 2*N; p++) run(2, p);
    for (int p = 1; p <= 2*N; p++) run(3, p);
    run(0, 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule